// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives an oversampling reference tick from the system clock by dividing it with a programmable 16.6 fixed-point divisor. The divisor is the system clock frequency divided by the oversampling ratio times the baud rate. The ratio is 16 in normal mode and 8 in high-speed mode. The integer part sets the base tick period in system clocks. The 6-bit fraction, in units of 1/64, is spread across periods by a small accumulator, so that 64 consecutive tick periods last exactly 64 × integer + fraction clocks. A second output, the bit strobe, divides the tick by the oversampling ratio to mark each bit period.

Software writes three plain register ports: an integer divisor, a fractional divisor and an 8-bit line-control word. The two divisor writes only load staging registers. A line-control write copies both staging values and the line-control word into the active configuration in a single edge, and restarts the divider. All ports are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `frac_baud_tick_gen`

## Requirements
- R1: After reset `tick` and `bit_strobe` are low, `lc_active` reads 0, and no tick is produced until a configuration with a nonzero integer is committed.
- R2: Each tick period lasts integer + c clocks. Here c is the carry out of adding the active fraction to a 6-bit accumulator that starts at zero and advances once per tick. The 64th tick after a commit falls exactly 64 × integer + fraction clocks after the commit edge.
- R3: Writes to the integer or fraction staging registers change neither the tick timing nor `lc_active` until a line-control write occurs. `lc_active` changes only on a line-control write.
- R4: All four update orders take effect on the line-control write: integer, fraction, line-control; fraction, integer, line-control; integer, line-control; fraction, line-control. A staging register that was not rewritten keeps its previous value.
- R5: A staging write and a line-control write in the same cycle commit the newly written staging value.
- R6: A commit restarts the period counter, the fraction accumulator and the oversample counter from zero. The first tick then falls in clock integer + (fraction ≥ 64 ? 1 : 0) after the commit edge, which is clock integer for any valid fraction.
- R7: While the committed integer divisor is zero, neither `tick` nor `bit_strobe` is ever asserted.
- R8: Bit 5 of the line-control word selects the oversampling ratio: 16 when clear, 8 when set. `bit_strobe` is high together with every 16th (or 8th) tick counted from the commit, and never without a tick.
- R9: With integer 1 and fraction 0, `tick` is high on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_wr | input | 1 | Write strobe for the integer staging register |
| int_wdata | input | 16 | Integer divisor value |
| frac_wr | input | 1 | Write strobe for the fraction staging register |
| frac_wdata | input | 6 | Fractional divisor value in 1/64 units |
| lc_wr | input | 1 | Line-control write strobe; commits the whole configuration |
| lc_wdata | input | 8 | Line-control word; bit 5 selects 8x oversampling |
| tick | output | 1 | Single-cycle oversampling reference tick |
| bit_strobe | output | 1 | Single-cycle bit-period strobe, coincident with a tick |
| lc_active | output | 8 | Committed line-control word |

## Verification
A commit can land in the same cycle as a tick that is due under the old divisor, and in the same cycle as a staging write. The bench provokes both by committing at arbitrary points in a running tick stream, and by pulsing `int_wr` together with `lc_wr`. A behavioural model places the k-th tick after each commit at clock k × integer + ⌊k × fraction / 64⌋. The model honours the old configuration up to the commit edge and the new one after it. It compares `tick`, `bit_strobe` and `lc_active` on every clock.

// File: rtl/fbt_pkg.sv
package fbt_pkg;

  // Oversampling mode carried by the committed line-control word
  typedef enum logic {
    OS_X16 = 1'b0,
    OS_X8  = 1'b1
  } os_mode_e;

endpackage

// File: rtl/fbt_cfg_regs.sv
module fbt_cfg_regs #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_wr,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_wr,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              lc_wr,
  input  logic [LC_W-1:0]   lc_wdata,
  output logic [INT_W-1:0]  act_int,
  output logic [FRAC_W-1:0] act_frac,
  output logic [LC_W-1:0]   act_lc,
  output logic              commit
);

  logic [INT_W-1:0]  int_stg;
  logic [FRAC_W-1:0] frac_stg;
  logic [INT_W-1:0]  int_src;
  logic [FRAC_W-1:0] frac_src;

  // a staging write in the commit cycle is forwarded into the commit
  assign int_src  = int_wr  ? int_wdata  : int_stg;
  assign frac_src = frac_wr ? frac_wdata : frac_stg;
  assign commit   = lc_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_stg  <= '0;
      frac_stg <= '0;
    end else begin
      if (int_wr)  int_stg  <= int_wdata;
      if (frac_wr) frac_stg <= frac_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_int  <= '0;
      act_frac <= '0;
      act_lc   <= '0;
    end else if (lc_wr) begin
      act_int  <= int_src;
      act_frac <= frac_src;
      act_lc   <= lc_wdata;
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lc_wr |=> ($stable(act_int) && $stable(act_frac) && $stable(act_lc))); // R3

  AST_SAME_CYCLE_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (lc_wr && int_wr) |=> (act_int == $past(int_wdata))); // R5

endmodule

// File: rtl/fbt_frac_period.sv
module fbt_frac_period #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);

  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;
  logic              carry;
  logic              enabled;
  logic [INT_W:0]    period_last;

  assign acc_sum     = {1'b0, acc} + {1'b0, div_frac};
  assign carry       = acc_sum[FRAC_W];
  assign enabled     = (div_int != '0);
  // last count of this period: integer - 1, plus one when the fraction carries
  assign period_last = {1'b0, div_int} + {{INT_W{1'b0}}, carry} - {{INT_W{1'b0}}, 1'b1};
  assign tick        = enabled && ({1'b0, cnt} == period_last);

  always_ff @(posedge clk) begin
    if (!rst_n || commit || !enabled) begin
      cnt <= '0;
      acc <= '0;
    end else if (tick) begin
      cnt <= '0;
      acc <= acc_sum[FRAC_W-1:0];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt == '0 && acc == '0)); // R6

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit) |=> $stable(acc)); // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |-> ({1'b0, cnt} <= period_last)); // R2

endmodule

// File: rtl/fbt_os_divider.sv
module fbt_os_divider
  import fbt_pkg::*;
#(
  parameter int OS_LOG = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  logic     tick,
  input  os_mode_e mode,
  output logic     bit_strobe
);

  localparam logic [OS_LOG-1:0] LAST_FULL = {OS_LOG{1'b1}};
  localparam logic [OS_LOG-1:0] LAST_HALF = {1'b0, {(OS_LOG-1){1'b1}}};

  logic [OS_LOG-1:0] os_cnt;
  logic [OS_LOG-1:0] os_last;

  assign os_last    = (mode == OS_X8) ? LAST_HALF : LAST_FULL;
  assign bit_strobe = tick && (os_cnt == os_last);

  always_ff @(posedge clk) begin
    if (!rst_n || commit) begin
      os_cnt <= '0;
    end else if (tick) begin
      os_cnt <= bit_strobe ? '0 : os_cnt + 1'b1;
    end
  end

  AST_OS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit) |=> $stable(os_cnt)); // R8

  AST_OS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (os_cnt == '0)); // R6

endmodule

// File: rtl/frac_baud_tick_gen.sv
module frac_baud_tick_gen
  import fbt_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LC_W   = 8,
  parameter int HS_BIT = 5,
  parameter int OS_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_wr,
  input  logic [INT_W-1:0]  int_wdata,
  input  logic              frac_wr,
  input  logic [FRAC_W-1:0] frac_wdata,
  input  logic              lc_wr,
  input  logic [LC_W-1:0]   lc_wdata,
  output logic              tick,
  output logic              bit_strobe,
  output logic [LC_W-1:0]   lc_active
);

  logic [INT_W-1:0]  act_int;
  logic [FRAC_W-1:0] act_frac;
  logic              commit;
  os_mode_e          mode;

  fbt_cfg_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LC_W(LC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_wr     (int_wr),
    .int_wdata  (int_wdata),
    .frac_wr    (frac_wr),
    .frac_wdata (frac_wdata),
    .lc_wr      (lc_wr),
    .lc_wdata   (lc_wdata),
    .act_int    (act_int),
    .act_frac   (act_frac),
    .act_lc     (lc_active),
    .commit     (commit)
  );

  assign mode = os_mode_e'(lc_active[HS_BIT]);

  fbt_frac_period #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_period (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .div_int  (act_int),
    .div_frac (act_frac),
    .tick     (tick)
  );

  fbt_os_divider #(.OS_LOG(OS_LOG)) u_os (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit),
    .tick       (tick),
    .mode       (mode),
    .bit_strobe (bit_strobe)
  );

  AST_STROBE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> tick); // R8

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (act_int == '0) |-> (!tick && !bit_strobe)); // R7

endmodule

// File: tb/test_frac_baud_tick_gen.sv
`timescale 1ns/1ps
module test_frac_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_wr = 1'b0;
  logic [15:0] int_wdata = '0;
  logic        frac_wr = 1'b0;
  logic [5:0]  frac_wdata = '0;
  logic        lc_wr = 1'b0;
  logic [7:0]  lc_wdata = '0;
  logic        tick;
  logic        bit_strobe;
  logic [7:0]  lc_active;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_tick_gen i_frac_baud_tick_gen (
    .clk(clk), .rst_n(rst_n),
    .int_wr(int_wr), .int_wdata(int_wdata),
    .frac_wr(frac_wr), .frac_wdata(frac_wdata),
    .lc_wr(lc_wr), .lc_wdata(lc_wdata),
    .tick(tick), .bit_strobe(bit_strobe), .lc_active(lc_active)
  );

  // behavioural reference model: k-th tick after commit at k*N + floor(k*F/64)
  longint m_int_stg, m_frac_stg, m_n, m_f, m_cyc, m_k;
  int     m_lc;
  longint dut_ticks;
  bit     started = 1'b0;

  function automatic bit exp_tick();
    longint nk = m_k + 1;
    if (m_n == 0) return 1'b0;
    return m_cyc == nk * m_n + (nk * m_f) / 64;
  endfunction

  function automatic bit exp_strobe();
    longint ratio = ((m_lc >> 5) & 1) != 0 ? 8 : 16;
    return exp_tick() && (((m_k + 1) % ratio) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_int_stg = 0; m_frac_stg = 0; m_n = 0; m_f = 0;
      m_cyc = 0; m_k = 0; m_lc = 0; dut_ticks = 0;
    end else begin
      if (exp_tick()) m_k++;
      m_cyc++;
      if (int_wr)  m_int_stg  = longint'(int_wdata);
      if (frac_wr) m_frac_stg = longint'(frac_wdata);
      if (lc_wr) begin
        m_n = m_int_stg; m_f = m_frac_stg; m_lc = int'(lc_wdata);
        m_cyc = 1; m_k = 0; dut_ticks = 0;
      end
    end
    started = 1'b1;
  end

  task automatic check(input bit ok, input string what, input longint got, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", what, got, exp, $time);
    end
  endtask

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && started && !done) begin
      check(tick == exp_tick(), "R2/R6 tick", tick, exp_tick());
      check(bit_strobe == exp_strobe(), "R8 bit_strobe", bit_strobe, exp_strobe());
      check(lc_active == m_lc[7:0], "R3 lc_active", lc_active, m_lc);
      if (tick) begin
        dut_ticks++;
        if (dut_ticks == 64)
          check(m_cyc == 64 * m_n + m_f, "R2 64-period span", m_cyc, 64 * m_n + m_f);
      end
    end
  end

  task automatic wr(input bit ie, input int iv, input bit fe, input int fv,
                    input bit le, input int lv);
    @(negedge clk);
    int_wr = ie; int_wdata = 16'(iv);
    frac_wr = fe; frac_wdata = 6'(fv);
    lc_wr = le; lc_wdata = 8'(lv);
    @(negedge clk);
    int_wr = 1'b0; frac_wr = 1'b0; lc_wr = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tick == 1'b0, "R1 tick at reset", tick, 0);
    check(bit_strobe == 1'b0, "R1 strobe at reset", bit_strobe, 0);
    check(lc_active == 8'h00, "R1 lc_active at reset", lc_active, 0);
    rst_n = 1'b1;
    run(40);                                  // R1/R7: no ticks with zero divisor
    check(dut_ticks == 0, "R1 no tick before commit", dut_ticks, 0);

    // R4 order 1: integer, fraction, line-control
    wr(1, 5, 0, 0, 0, 0); wr(0, 0, 1, 13, 0, 0); wr(0, 0, 0, 0, 1, 8'h03);
    run(5 * 64 + 40);
    // R3: staging writes without commit have no effect
    wr(1, 3, 0, 0, 0, 0); wr(0, 0, 1, 40, 0, 0);
    run(200);
    check(lc_active == 8'h03, "R3 lc_active unchanged", lc_active, 3);
    // R4 order 2: fraction, integer, line-control (commits mid-stream, R6)
    wr(0, 0, 1, 63, 0, 0); wr(1, 2, 0, 0, 0, 0); wr(0, 0, 0, 0, 1, 8'h20);
    run(3 * 64 + 40);
    // R4 order 3: integer then line-control, fraction 63 kept
    wr(1, 4, 0, 0, 0, 0); wr(0, 0, 0, 0, 1, 8'h00);
    run(5 * 64 + 40);
    // R4 order 4: fraction then line-control, integer 4 kept
    wr(0, 0, 1, 1, 0, 0); wr(0, 0, 0, 0, 1, 8'h20);
    run(5 * 64 + 40);
    // R5: integer write and commit in the same cycle
    wr(1, 7, 0, 0, 1, 8'h00);
    run(7 * 64 + 40);
    // R9: integer 1, fraction 0, every clock a tick; 8x mode
    wr(1, 1, 1, 0, 1, 8'h20);
    run(100);
    check(tick == 1'b1, "R9 continuous tick", tick, 1);
    // integer 1 with fraction 32: alternating 1 and 2 clock periods
    wr(0, 0, 1, 32, 1, 8'h00);
    run(200);
    // R7: zero integer commits stop all ticks
    wr(1, 0, 1, 9, 1, 8'h20);
    dut_ticks = 0;
    run(150);
    check(dut_ticks == 0, "R7 no tick with zero integer", dut_ticks, 0);
    // recovery with a fresh divisor
    wr(1, 3, 1, 50, 1, 8'h00);
    run(3 * 64 + 60);
    finish_run();
  end

endmodule